// File: doc/BRIEF.md
# Multi-Channel Conversion Sequencer

This block sits between a register bus and one shared analog-to-digital converter. It holds four independent sequencers. Each sequencer has a table of up to eight entries. An entry names an input channel and carries four control bits. Each sequencer also has its own result queue. Software starts a sequencer by writing its bit in a start register. A sequencer can instead be started by a rising edge on one of four external trigger lines, chosen by a per-sequencer select code.

When several sequencers are waiting, the lowest-numbered one is served first. A running sequence is never interrupted. The sequence steps through its entries and, for each entry, requests one or more conversions from the converter port. When hardware averaging is enabled, 2^k conversions are summed and the sum is shifted right by k. The averaged 12-bit result is pushed into the sequencer's queue.

An entry can mark itself as the last one, and it can ask for a completion flag. Completion flags, queue overflow flags and queue underflow flags are held in one status word. Software clears any of these flags by writing 1s to a clear register.

Top module: `adcseq_top`

## Requirements
- R1: After reset the status word reads 0, `conv_req` is low and no conversion has been requested.
- R2: Writing 1 to bit n of the start register (address 0x01) starts sequencer n. Entries are converted in table order starting at entry 0. Entry byte e of sequencer n is written at address 0x20+8n+e. Bits 3:0 of the entry byte give the channel. While the entry is served, `conv_chan` carries that channel, `conv_diff` carries bit 4 and `conv_temp` carries bit 7. The channel is held stable while a request is waiting for its acknowledge.
- R3: A sequence ends after the entry whose bit 5 (last) is set. If no entry has that bit set, the sequence ends after entry 7. No further conversion is requested for that start.
- R4: Status bit n (bits 3:0 of the word at address 0x02) is set when sequencer n stores the result of an entry whose bit 6 (flag enable) is 1. An entry with bit 6 clear leaves the status bit at 0.
- R5: Writing to the clear register (address 0x03) clears each status bit whose write bit is 1. Write bits that are 0 leave their status bits unchanged.
- R6: Waiting sequencers are served lowest-numbered first. A sequence that is running finishes all its entries before another sequencer is chosen.
- R7: The trigger select register (address 0x00) holds a 4-bit code for each sequencer, in bits 4n+3:4n. Code 0 means software start only. A code k from 1 to 4 also starts the sequencer on a rising edge of `trig_in[k-1]`. Edges on the other trigger lines do not start it.
- R8: The averaging register (address 0x04, bits 2:0) holds k. Each entry then takes 2^k conversions and stores the sum shifted right by k. Values of k above 6 act as 6.
- R9: Each sequencer's queue holds 8 results. Reading address 0x08+n returns the oldest result of sequencer n in bits 11:0 and removes it from the queue.
- R10: If a result arrives while a queue is full, the result is dropped and sticky status bit 4+n is set. Reading an empty queue returns 0 and sets sticky status bit 8+n. Both sticky bits are cleared through the clear register at the same bit positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 6 | Register address |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe; when the address selects a queue, a read removes one result |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from address) |
| trig_in | input | 4 | External trigger lines |
| conv_req | output | 1 | Conversion request, held until acknowledged |
| conv_chan | output | 4 | Channel for the requested conversion |
| conv_diff | output | 1 | Differential mode for the requested conversion |
| conv_temp | output | 1 | Temperature-sensor select for the requested conversion |
| conv_ack | input | 1 | One-cycle acknowledge carrying the result |
| conv_data | input | 12 | Conversion result, valid with `conv_ack` |

## Verification
The assertions check several properties on every cycle:
- the arbiter's grant is one-hot, is a subset of the waiting sequencers, and has no lower-numbered waiter;
- the channel stays stable while a request is waiting;
- the running sequencer does not change in the middle of a sequence;
- a queue's fill level never passes its depth;
- status bits rise only together with a flagged store, and clear writes take effect.

Only the bench's scenarios show the following, because each depends on knowing the converter data and the order of results:
- entry order and the stop at the last entry or at entry 7;
- the averaged values;
- trigger-line selection;
- that nothing is preempted when a start arrives mid-sequence;
- that the first eight results survive an overflow.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
    localparam int NSEQ        = 4;
    localparam int NENT        = 8;
    localparam int DW          = 12;
    localparam int CHW         = 4;
    localparam int NTRIG       = 4;
    localparam int AVG_MAX_LOG = 6;
    localparam int FIFO_DEPTH  = 8;
    localparam int SEQW        = $clog2(NSEQ);
    localparam int ENTW        = $clog2(NENT);
    localparam int ACCW        = DW + AVG_MAX_LOG;

    localparam logic [5:0] A_TRIGSEL = 6'h00;
    localparam logic [5:0] A_START   = 6'h01;
    localparam logic [5:0] A_STATUS  = 6'h02;
    localparam logic [5:0] A_CLEAR   = 6'h03;
    localparam logic [5:0] A_AVG     = 6'h04;
    localparam logic [5:0] A_FIFO    = 6'h08;
    localparam logic [5:0] A_ENTRY   = 6'h20;

    typedef struct packed {
        logic           temp;
        logic           flag_en;
        logic           last;
        logic           diff;
        logic [CHW-1:0] chan;
    } entry_t;

    typedef enum logic {ENG_IDLE, ENG_CONV} eng_state_t;

    function automatic logic [2:0] clamp_avg(input logic [2:0] k);
        return (k > 3'(AVG_MAX_LOG)) ? 3'(AVG_MAX_LOG) : k;
    endfunction
endpackage

// File: rtl/adcseq_fifo.sv
module adcseq_fifo #(
    parameter int DW    = 12,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          ovf,
    output logic          unf
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_p, rd_p;
    logic [CW-1:0] count;
    logic          full, empty, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign ovf     = push && full;
    assign unf     = pop && empty;
    assign dout    = empty ? '0 : mem[rd_p];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_p  <= '0;
            rd_p  <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                mem[wr_p] <= din;
                wr_p      <= AW'((32'(wr_p) + 1) % DEPTH);
            end
            if (do_pop) rd_p <= AW'((32'(rd_p) + 1) % DEPTH);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // R10
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    // R10
    drop_on_full_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/adcseq_arb.sv
module adcseq_arb #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         pend,
    output logic [N-1:0]         gnt,
    output logic [$clog2(N)-1:0] gnt_idx,
    output logic                 any
);
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                gnt     = '0;
                gnt[i]  = 1'b1;
                gnt_idx = $clog2(N)'(i);
            end
        end
    end
    assign any = |pend;

    // R6
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt) && ((gnt & ~pend) == '0) && (any == (gnt != '0)));
    // R6
    grant_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        ((gnt - N'(1)) & pend & ~gnt) == '0);
endmodule

// File: rtl/adcseq_engine.sv
module adcseq_engine
    import adcseq_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      pend_any,
    input  logic [SEQW-1:0]           gnt_idx,
    input  entry_t [NSEQ*NENT-1:0]    table_i,
    input  logic [2:0]                avg_log,
    output logic                      take,
    output logic                      conv_req,
    output logic [CHW-1:0]            conv_chan,
    output logic                      conv_diff,
    output logic                      conv_temp,
    input  logic                      conv_ack,
    input  logic [DW-1:0]             conv_data,
    output logic                      push,
    output logic [SEQW-1:0]           push_seq,
    output logic [DW-1:0]             push_data,
    output logic                      flag_set
);
    eng_state_t              state;
    logic [SEQW-1:0]         seq;
    logic [ENTW-1:0]         ent;
    logic [AVG_MAX_LOG-1:0]  cnt;
    logic [ACCW-1:0]         acc, acc_n;
    logic [2:0]              avg_q;
    logic [AVG_MAX_LOG:0]    lim;
    entry_t                  cur;
    logic                    cnt_done, seq_end;

    assign cur       = table_i[{seq, ent}];
    assign take      = (state == ENG_IDLE) && pend_any;
    assign conv_req  = (state == ENG_CONV);
    assign conv_chan = cur.chan;
    assign conv_diff = cur.diff;
    assign conv_temp = cur.temp;

    assign acc_n     = acc + ACCW'(conv_data);
    assign lim       = ((AVG_MAX_LOG+1)'(1) << avg_q) - (AVG_MAX_LOG+1)'(1);
    assign cnt_done  = ({1'b0, cnt} == lim);
    assign push      = conv_req && conv_ack && cnt_done;
    assign push_seq  = seq;
    assign push_data = DW'(acc_n >> avg_q);
    assign flag_set  = push && cur.flag_en;
    assign seq_end   = cur.last || (ent == ENTW'(NENT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ENG_IDLE;
            seq   <= '0;
            ent   <= '0;
            cnt   <= '0;
            acc   <= '0;
            avg_q <= '0;
        end else if (take) begin
            state <= ENG_CONV;
            seq   <= gnt_idx;
            ent   <= '0;
            cnt   <= '0;
            acc   <= '0;
            avg_q <= clamp_avg(avg_log);
        end else if (conv_req && conv_ack) begin
            if (cnt_done) begin
                cnt <= '0;
                acc <= '0;
                if (seq_end) state <= ENG_IDLE;
                else         ent   <= ent + 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
                acc <= acc_n;
            end
        end
    end

    // R2
    chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_req && !conv_ack) |=> (conv_req && $stable(conv_chan)));
    // R6
    no_preempt_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_req && !(push && seq_end)) |=> (conv_req && $stable(seq)));
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
    import adcseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [5:0]       bus_addr,
    input  logic             bus_we,
    input  logic             bus_re,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [NTRIG-1:0] trig_in,
    output logic             conv_req,
    output logic [CHW-1:0]   conv_chan,
    output logic             conv_diff,
    output logic             conv_temp,
    input  logic             conv_ack,
    input  logic [DW-1:0]    conv_data
);
    entry_t [NSEQ*NENT-1:0] tbl;
    logic [NSEQ-1:0][3:0]   trig_sel;
    logic [2:0]             avg_log;
    logic [NSEQ-1:0]        pend, raw, ovf_st, unf_st, hw_hit, gnt, take_mask;
    logic [NSEQ-1:0]        sw_set, raw_set, clr_raw, ovf_p, unf_p, pop;
    logic [NSEQ-1:0][DW-1:0] fifo_out;
    logic [NTRIG-1:0]       trig_q, rise;
    logic [SEQW-1:0]        gnt_idx, push_seq;
    logic                   any, take, push, flag_set, wr_clr;
    logic [DW-1:0]          push_data;

    assign rise    = trig_in & ~trig_q;
    assign sw_set  = (bus_we && bus_addr == A_START) ? bus_wdata[NSEQ-1:0] : '0;
    assign wr_clr  = bus_we && (bus_addr == A_CLEAR);
    assign clr_raw = wr_clr ? bus_wdata[NSEQ-1:0] : '0;
    assign take_mask = take ? gnt : '0;

    for (genvar s = 0; s < NSEQ; s++) begin : g_seq
        assign hw_hit[s]  = (trig_sel[s] != 4'd0) && (trig_sel[s] <= 4'(NTRIG))
                            && rise[2'(trig_sel[s] - 4'd1)];
        assign raw_set[s] = flag_set && (push_seq == SEQW'(s));
        assign pop[s]     = bus_re && (bus_addr == A_FIFO + 6'(s));

        adcseq_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) fifo_i (
            .clk(clk), .rst(rst),
            .push(push && (push_seq == SEQW'(s))), .din(push_data),
            .pop(pop[s]), .dout(fifo_out[s]), .ovf(ovf_p[s]), .unf(unf_p[s])
        );
    end

    adcseq_arb #(.N(NSEQ)) arb_i (
        .clk(clk), .rst(rst), .pend(pend),
        .gnt(gnt), .gnt_idx(gnt_idx), .any(any)
    );

    adcseq_engine eng_i (
        .clk(clk), .rst(rst), .pend_any(any), .gnt_idx(gnt_idx),
        .table_i(tbl), .avg_log(avg_log), .take(take),
        .conv_req(conv_req), .conv_chan(conv_chan), .conv_diff(conv_diff),
        .conv_temp(conv_temp), .conv_ack(conv_ack), .conv_data(conv_data),
        .push(push), .push_seq(push_seq), .push_data(push_data),
        .flag_set(flag_set)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl      <= '0;
            trig_sel <= '0;
            avg_log  <= '0;
            pend     <= '0;
            raw      <= '0;
            ovf_st   <= '0;
            unf_st   <= '0;
            trig_q   <= '0;
        end else begin
            trig_q <= trig_in;
            pend   <= (pend & ~take_mask) | sw_set | hw_hit;
            raw    <= (raw & ~clr_raw) | raw_set;
            ovf_st <= (ovf_st & ~(wr_clr ? bus_wdata[2*NSEQ-1:NSEQ] : '0)) | ovf_p;
            unf_st <= (unf_st & ~(wr_clr ? bus_wdata[3*NSEQ-1:2*NSEQ] : '0)) | unf_p;
            if (bus_we) begin
                if (bus_addr == A_TRIGSEL) trig_sel <= bus_wdata[4*NSEQ-1:0];
                if (bus_addr == A_AVG)     avg_log  <= bus_wdata[2:0];
                if (bus_addr[5]) tbl[{bus_addr[SEQW+ENTW-1:ENTW], bus_addr[ENTW-1:0]}]
                                     <= bus_wdata[7:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_TRIGSEL: bus_rdata = 32'(trig_sel);
            A_STATUS:  bus_rdata = 32'({unf_st, ovf_st, raw});
            A_AVG:     bus_rdata = 32'(avg_log);
            default: begin
                for (int s = 0; s < NSEQ; s++)
                    if (bus_addr == A_FIFO + 6'(s)) bus_rdata = 32'(fifo_out[s]);
            end
        endcase
    end

    // R4
    raw_rise_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((raw & ~$past(raw) & ~$past(raw_set)) == '0));
    // R5
    raw_clear_chk: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> ((raw & $past(clr_raw & ~raw_set)) == '0));
endmodule

// File: tb/adcseq_top_tb_top.sv
module adcseq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [3:0]  trig_in = '0;
    logic        conv_req, conv_diff, conv_temp;
    logic [3:0]  conv_chan;
    logic        conv_ack = 1'b0;
    logic [11:0] conv_data = '0;

    int checks = 0, fails = 0, n_conv = 0, lat = 0;
    int log_chan [0:511];
    int log_data [0:511];
    int log_diff [0:511];
    int log_temp [0:511];

    always #10 clk = ~clk;

    adcseq_top dut_i (.*);

    // converter model: acknowledge three cycles after request
    always @(posedge clk) begin
        if (conv_ack) begin
            conv_ack <= 1'b0;
            lat = 0;
        end else if (conv_req) begin
            if (lat == 2) begin
                conv_ack  <= 1'b1;
                conv_data <= {conv_chan, 8'(n_conv * 7 + 3)};
                log_chan[n_conv] = int'(conv_chan);
                log_data[n_conv] = int'({conv_chan, 8'(n_conv * 7 + 3)});
                log_diff[n_conv] = int'(conv_diff);
                log_temp[n_conv] = int'(conv_temp);
                n_conv++;
                lat = 0;
            end else lat++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output int d);
        @(negedge clk); bus_addr = a; bus_re = 1'b1;
        #2 d = int'(bus_rdata);
        @(negedge clk); bus_re = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        repeat (3) @(negedge clk);
        while (quiet < 10) begin
            @(negedge clk);
            quiet = conv_req ? 0 : quiet + 1;
        end
    endtask

    task automatic t_reset();
        int d;
        rd(6'h02, d);
        chk("R1 status", d, 0);
        chk("R1 conv_req", int'(conv_req), 0);
        chk("R1 no conversions", n_conv, 0);
    endtask

    task automatic t_single();
        int d, b;
        wr(6'h20 + 6'd24, 32'h65);        // seq3 entry0: chan 5, last+flag
        b = n_conv;
        wr(6'h01, 32'h8);
        wait_idle();
        chk("R2 one conversion", n_conv - b, 1);
        chk("R2 channel", log_chan[b], 5);
        rd(6'h02, d);
        chk("R4 flag set", d & 32'hF, 32'h8);
        rd(6'h0B, d);
        chk("R9 result", d, log_data[b]);
        rd(6'h0B, d);
        chk("R10 empty read zero", d, 0);
        rd(6'h02, d);
        chk("R10 underflow sticky", d, 32'h808);
        wr(6'h03, 32'h0);
        rd(6'h02, d);
        chk("R5 zero write no effect", d, 32'h808);
        wr(6'h03, 32'h808);
        rd(6'h02, d);
        chk("R5 cleared", d, 0);
    endtask

    task automatic t_multi();
        int d, b;
        wr(6'h28, 32'h02);                // seq1: chan 2
        wr(6'h29, 32'h97);                // chan 7, diff+temp
        wr(6'h2A, 32'h69);                // chan 9, last+flag
        wr(6'h2B, 32'h6C);                // must not be reached
        b = n_conv;
        wr(6'h01, 32'h2);
        wait_idle();
        chk("R3 stop at last", n_conv - b, 3);
        chk("R2 order e0", log_chan[b], 2);
        chk("R2 order e1", log_chan[b+1], 7);
        chk("R2 order e2", log_chan[b+2], 9);
        chk("R2 diff/temp", log_diff[b+1] * 2 + log_temp[b+1], 3);
        chk("R2 plain entry", log_diff[b] * 2 + log_temp[b], 0);
        for (int k = 0; k < 3; k++) begin
            rd(6'h09, d);
            chk("R9 fifo order", d, log_data[b+k]);
        end
        rd(6'h02, d);
        chk("R4 flag seq1", d, 32'h2);
        wr(6'h03, 32'h2);
    endtask

    task automatic t_eight();
        int d, b;
        for (int e = 0; e < 8; e++) wr(6'h30 + 6'(e), 32'(e + 4));
        b = n_conv;
        wr(6'h01, 32'h4);
        wait_idle();
        chk("R3 stop after entry 7", n_conv - b, 8);
        chk("R2 entry 7 channel", log_chan[b+7], 11);
        rd(6'h02, d);
        chk("R4 no flag without enable", d, 0);
        for (int k = 0; k < 8; k++) begin
            rd(6'h0A, d);
            chk("R9 eight results", d, log_data[b+k]);
        end
    endtask

    task automatic t_priority();
        int d, b;
        wr(6'h20, 32'h63);                // seq0: chan 3
        wr(6'h30, 32'h6B);                // seq2: chan 11
        b = n_conv;
        wr(6'h01, 32'h5);
        wait_idle();
        chk("R6 lowest first", log_chan[b], 3);
        chk("R6 then seq2", log_chan[b+1], 11);
        b = n_conv;
        wr(6'h01, 32'h2);
        repeat (2) @(negedge clk);
        wr(6'h01, 32'h1);
        wait_idle();
        chk("R6 no preempt count", n_conv - b, 4);
        chk("R6 no preempt e2", log_chan[b+2], 9);
        chk("R6 seq0 after", log_chan[b+3], 3);
        for (int k = 0; k < 3; k++) rd(6'h09, d);
        for (int k = 0; k < 2; k++) rd(6'h08, d);
        rd(6'h0A, d);
        wr(6'h03, 32'h7);
        rd(6'h02, d);
        chk("R5 clear many", d, 0);
    endtask

    task automatic t_trigger();
        int d, b;
        wr(6'h00, 32'h2);                 // seq0 on trigger line 1
        b = n_conv;
        @(negedge clk); trig_in = 4'b0001;
        @(negedge clk); trig_in = 4'b0000;
        repeat (20) @(negedge clk);
        chk("R7 wrong line ignored", n_conv - b, 0);
        @(negedge clk); trig_in = 4'b0010;
        wait_idle();
        chk("R7 selected line starts", n_conv - b, 1);
        repeat (10) @(negedge clk);
        chk("R7 level no retrigger", n_conv - b, 1);
        trig_in = 4'b0000;
        rd(6'h08, d);
        chk("R7 result", d, log_data[b]);
        wr(6'h00, 32'h0);
        wr(6'h03, 32'h1);
    endtask

    task automatic t_avg();
        int d, b, s;
        wr(6'h04, 32'h2);
        b = n_conv;
        wr(6'h01, 32'h1);
        wait_idle();
        chk("R8 four conversions", n_conv - b, 4);
        s = 0;
        for (int k = 0; k < 4; k++) s += log_data[b+k];
        rd(6'h08, d);
        chk("R8 average of 4", d, s >> 2);
        wr(6'h04, 32'h7);
        b = n_conv;
        wr(6'h01, 32'h1);
        wait_idle();
        chk("R8 clamp to 64", n_conv - b, 64);
        s = 0;
        for (int k = 0; k < 64; k++) s += log_data[b+k];
        rd(6'h08, d);
        chk("R8 average of 64", d, s >> 6);
        wr(6'h04, 32'h0);
        wr(6'h03, 32'h1);
    endtask

    task automatic t_overflow();
        int d, b;
        b = n_conv;
        for (int k = 0; k < 9; k++) begin
            wr(6'h01, 32'h8);
            wait_idle();
        end
        rd(6'h02, d);
        chk("R10 overflow sticky", d, 32'h88);
        for (int k = 0; k < 8; k++) begin
            rd(6'h0B, d);
            chk("R10 kept oldest", d, log_data[b+k]);
        end
        wr(6'h03, 32'h88);
        rd(6'h02, d);
        chk("R10 sticky cleared", d, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single();
        t_multi();
        t_eight();
        t_priority();
        t_trigger();
        t_avg();
        t_overflow();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule